// File: doc/BRIEF.md
# Edge-Triggered Interrupt Combiner

This block merges a set of interrupt request lines into a single interrupt output. Because its only output is one request line, the same block can sit inside a functional unit, gather unit requests at chip level, or stand in front of a processor. Each incoming line first passes through a hold-time noise filter. A rising edge of the filtered level then sets a sticky pending bit. The output is a registered OR of the pending bits whose enable bits are set.

Software works through a small single-cycle register port. Through it, software reads the unfiltered line levels, the pending bits and the enables. It writes the enables, and it acknowledges pending bits by writing ones to them. The intended service loop acknowledges a request first and services the source afterwards. An edge that arrives after the acknowledge raises the request again, so no event is lost. A line that is already high when it is enabled does not interrupt. Software can still see that line in the raw levels and decide whether to act on it.

Top module: `irq_aggregator`

## Requirements
- R1: On synchronous active-high reset, all enable bits, all pending bits, `irq_o` and `bus_rdata` are zero. All enables read zero on the first cycle after reset.
- R2: The filtered level of a source changes only after the source has held the new value for `FILT_LEN` consecutive clock samples. A pulse lasting `FILT_LEN`-1 cycles sets no pending bit, and a pulse lasting `FILT_LEN` cycles does.
- R3: A pending bit is set only by a rising edge of its filtered level. A line that stays high after its acknowledge sets nothing more, and a falling edge sets nothing.
- R4: A line that is already high when reset is released, or when its enable is written, produces no pending bit and no interrupt.
- R5: A read at address 0 returns the current unfiltered level of every source line, with bit i for source i.
- R6: Address 1 holds the pending bits, with bit i for source i. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R7: Address 2 holds the enable bits, with bit i for source i. These bits are read/write.
- R8: `irq_o` equals the OR of (pending AND enable) as it stood one clock earlier. Clearing an enable masks the output but keeps the pending bit.
- R9: When a rising edge and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: Read data appears on `bus_rdata` one cycle after a read and holds while no read occurs. Address 3 reads zero. Writes to addresses 0 and 3 change no state.
- R11: An edge that arrives after an acknowledge sets the pending bit again and reasserts `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt request lines, one bit per source |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 raw levels, 1 pending, 2 enables |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data, registered |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
The hardest case to reach is R9, where an acknowledge write and a fresh filtered rising edge land on the same pending bit in the same clock. To get there, the bench first leaves the bit pending and returns the line low. It then raises the line and waits exactly `FILT_LEN` clock edges, so the filtered edge is visible. It issues the clear on the next edge and checks that the bit survives. Beyond that case, the bench sweeps every pending pattern against every enable pattern for four sources. For each pair it predicts the output and the partial clear results with plain bit arithmetic.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Register selects; the service software depends on these offsets.
    typedef enum logic [1:0] {
        SEL_RAW  = 2'd0,
        SEL_PEND = 2'd1,
        SEL_EN   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int unsigned ADDR_W = 2;

    // Control part of a register access (data travels separately).
    typedef struct packed {
        logic     valid;
        logic     write;
        reg_sel_e sel;
    } bus_req_t;

    function automatic bus_req_t make_req(input logic v, input logic w,
                                          input logic [ADDR_W-1:0] a);
        bus_req_t r;
        r.valid = v;
        r.write = w;
        r.sel   = reg_sel_e'(a);
        return r;
    endfunction

    function automatic logic is_write_to(input bus_req_t r, input reg_sel_e s);
        return r.valid && r.write && (r.sel == s);
    endfunction

    function automatic logic is_read(input bus_req_t r);
        return r.valid && !r.write;
    endfunction

endpackage

// File: rtl/irq_src_filter.sv
module irq_src_filter #(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    generate
        if (FILT_LEN <= 1) begin : g_bypass
            always_ff @(posedge clk) begin
                dout <= din;
            end
        end else begin : g_hold
            localparam int unsigned CW = $clog2(FILT_LEN);
            localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

            logic [CW-1:0] run_cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    dout    <= din;
                    run_cnt <= '0;
                end else if (din != dout) begin
                    if (run_cnt == LAST) begin
                        dout    <= din;
                        run_cnt <= '0;
                    end else begin
                        run_cnt <= run_cnt + 1'b1;
                    end
                end else begin
                    run_cnt <= '0;
                end
            end

            // R2
            run_bound_chk: assert property (@(posedge clk) disable iff (rst)
                run_cnt <= LAST);

            // R2
            filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
                (dout != $past(dout)) |-> (dout == $past(din)));
        end
    endgenerate

endmodule

// File: rtl/irq_src_edge.sv
module irq_src_edge (
    input  logic clk,
    input  logic rst,
    input  logic filt,
    input  logic clr,
    output logic rise,
    output logic pend
);
    logic prev;

    assign rise = filt & ~prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= filt;
            pend <= 1'b0;
        end else begin
            prev <= filt;
            // A simultaneous edge beats the clear.
            pend <= (pend & ~clr) | rise;
        end
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> pend);

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);

    // R3
    edge_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!rise && !pend) |=> !pend);

endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] rdata,
    output logic               irq
);
    assign clr = is_write_to(req, SEL_PEND) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= '0;
        end else if (is_write_to(req, SEL_EN)) begin
            en <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (is_read(req)) begin
            unique case (req.sel)
                SEL_RAW:  rdata <= raw;
                SEL_PEND: rdata <= pend;
                SEL_EN:   rdata <= en;
                default:  rdata <= '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(pend & en);
    end

    // R1
    en_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en == '0));

    // R8
    masked_chk: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |=> !irq);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !is_read(req) |=> $stable(rdata));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 8,
    parameter int unsigned FILT_LEN = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_SRC-1:0]  bus_wdata,
    output logic [NUM_SRC-1:0]  bus_rdata,
    output logic                irq_o
);
    bus_req_t           req;
    logic [NUM_SRC-1:0] filt;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] en;

    assign req = make_req(bus_valid, bus_write, bus_addr);

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            irq_src_filter #(.FILT_LEN(FILT_LEN)) u_filt (
                .clk  (clk),
                .rst  (rst),
                .din  (src_i[i]),
                .dout (filt[i])
            );

            irq_src_edge u_edge (
                .clk  (clk),
                .rst  (rst),
                .filt (filt[i]),
                .clr  (clr[i]),
                .rise (rise[i]),
                .pend (pend[i])
            );
        end
    endgenerate

    irq_agg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .wdata (bus_wdata),
        .raw   (src_i),
        .pend  (pend),
        .clr   (clr),
        .en    (en),
        .rdata (bus_rdata),
        .irq   (irq_o)
    );

    // R11
    reassert_chk: assert property (@(posedge clk) disable iff (rst)
        (|(rise & en)) |=> ##1 irq_o);

endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
    localparam int NS = 4;
    localparam int FL = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_i = '0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [NS-1:0] bus_wdata = '0;
    logic [NS-1:0] bus_rdata;
    logic          irq_o;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    irq_aggregator #(.NUM_SRC(NS), .FILT_LEN(FL)) dut (
        .clk(clk), .rst(rst), .src_i(src_i),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        cyc(1);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [NS-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        cyc(1);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        cyc(FL + 3);
    endtask

    task automatic clear_all();
        src_i = '0;
        settle();
        wr(2'd1, '1);
    endtask

    initial begin
        logic [NS-1:0] d;
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 rdata", int'(bus_rdata), 0);
        rd(2'd1, d); chk("R1 pend", int'(d), 0);
        rd(2'd2, d); chk("R1 en", int'(d), 0);
        rd(2'd3, d); chk("R10 addr3", int'(d), 0);

        // R5 raw sweep
        for (int v = 0; v < (1 << NS); v++) begin
            src_i = NS'(v);
            rd(2'd0, d);
            chk("R5 raw", int'(d), v);
        end
        clear_all();

        // R2 filter boundary
        src_i = 4'b0001; cyc(FL - 1); src_i = '0; settle();
        rd(2'd1, d); chk("R2 short pulse", int'(d), 0);
        src_i = 4'b0001; cyc(FL); src_i = '0; settle();
        rd(2'd1, d); chk("R2 full pulse", int'(d), 1);
        clear_all();

        // R3 held level and falling edge
        src_i = 4'b0100; settle();
        rd(2'd1, d); chk("R3 edge sets", int'(d), 4);
        wr(2'd1, 4'b0100); cyc(10);
        rd(2'd1, d); chk("R3 no retrigger", int'(d), 0);
        src_i = '0; settle();
        rd(2'd1, d); chk("R3 falling", int'(d), 0);

        // R4 line already high when enabled
        src_i = 4'b0010; settle();
        wr(2'd1, '1);
        wr(2'd2, '1); cyc(2);
        chk("R4 irq on enable", int'(irq_o), 0);
        rd(2'd0, d); chk("R5 raw visible", int'(d), 2);
        // R4 line high through reset
        src_i = 4'b1010;
        rst = 1'b1; cyc(3); rst = 1'b0; settle();
        rd(2'd1, d); chk("R4 pend after reset", int'(d), 0);
        rd(2'd2, d); chk("R1 en after reset", int'(d), 0);
        chk("R4 irq after reset", int'(irq_o), 0);

        // R6/R7/R8 sweep of pending against enable patterns
        for (int p = 0; p < (1 << NS); p++) begin
            for (int e = 0; e < (1 << NS); e++) begin
                clear_all();
                src_i = NS'(p); settle();
                rd(2'd1, d); chk("R3 pend pattern", int'(d), p);
                wr(2'd2, NS'(e));
                chk("R8 irq latency", int'(irq_o), 0);
                cyc(1);
                chk("R8 irq", int'(irq_o), int'(|(NS'(p) & NS'(e))));
                rd(2'd2, d); chk("R7 en", int'(d), e);
                wr(2'd1, NS'(e));
                rd(2'd1, d); chk("R6 w1c", int'(d), p & ~e);
                wr(2'd2, '0); cyc(1);
                chk("R8 masked", int'(irq_o), 0);
                rd(2'd1, d); chk("R8 pend kept", int'(d), p & ~e);
            end
        end

        // R10 writes to read-only / unused addresses
        clear_all();
        src_i = 4'b0011; settle();
        wr(2'd2, 4'b0101);
        wr(2'd0, '1);
        wr(2'd3, '1);
        rd(2'd2, d); chk("R10 en untouched", int'(d), 5);
        rd(2'd1, d); chk("R10 pend untouched", int'(d), 3);

        // R9 clear and edge in the same cycle
        clear_all();
        src_i = 4'b0010; settle();
        src_i = '0; settle();
        rd(2'd1, d); chk("R9 setup", int'(d), 2);
        src_i = 4'b0010; cyc(FL);
        wr(2'd1, 4'b0010);
        rd(2'd1, d); chk("R9 set wins", int'(d), 2);
        wr(2'd1, 4'b0010);
        rd(2'd1, d); chk("R6 later clear", int'(d), 0);

        // R11 ack then new edge
        clear_all();
        wr(2'd2, '1);
        src_i = 4'b1000; settle();
        chk("R11 irq up", int'(irq_o), 1);
        wr(2'd1, 4'b1000); cyc(1);
        chk("R11 irq after ack", int'(irq_o), 0);
        src_i = '0; settle();
        src_i = 4'b1000; settle();
        chk("R11 irq reasserts", int'(irq_o), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule